// File: doc/BRIEF.md
# Hamming-protected packet byte extractor

This block sits behind the data slicer and framer of a vertical-blanking data receiver. It takes the byte stream of one data line, already tagged by upstream logic with its row designation and packet format number, and acquires only the service-data row. Two formats are kept. The coded format carries Hamming 8/4 protected bytes; these are checked, single-bit errors are repaired and the repaired bytes are stored. The raw format carries date and time bytes, which are copied exactly as received.

Bytes are first gathered in a line staging buffer. At the end of the line the whole packet is committed to the matching acquisition bank in one cycle, or dropped as a unit. A completed coded-format commit pulls an active-low data-valid flag low. The flag is released at the start of the next data entry window. A store-enable input lets an external interlock, such as a host read in progress, hold the banks unchanged.

Top module: `hamm_pkt_extract`

## Requirements
- R1: After reset, `data_valid_n` is 1, `wr_stb` is 0, and every byte of `coded_bank` and `raw_bank` reads 8'hFF.
- R2: A packet whose `pkt_row` differs from SVC_ROW (30), or whose `pkt_fmt` is neither 1 (raw) nor 2 (coded), writes nothing: the banks, `wr_stb` and `data_valid_n` are unchanged.
- R3: Byte positions count from 0, the first `byte_vld` byte after `pkt_start`. For format 2, positions 13 to 25 are stored, with position 13+k in `coded_bank[8k+7:8k]`.
- R4: Coded bytes use Hamming 8/4 with data in bits 1, 3, 5, 7 and protection in bits 0, 2, 4, 6. The checks are A = b0^b1^b5^b7, B = b1^b2^b3^b7, C = b1^b3^b4^b5, plus even parity over all 8 bits. A byte with one flipped bit, in any position, is stored as the corrected codeword.
- R5: A coded byte inside the window that has a nonzero A/B/C syndrome and even overall parity (a double error) drops the whole packet. The coded bank keeps its previous contents.
- R6: For format 1, positions 15 to 21 are stored bit for bit, with no checking, in `raw_bank[8k+7:8k]` for position 15+k. This includes bytes that are not valid codewords.
- R7: A coded commit drives `data_valid_n` low from the clock edge that samples `pkt_end`. A raw commit never changes `data_valid_n`.
- R8: `data_valid_n` returns to 1 on the edge after `field_start` is sampled high. `field_start` wins over a coded commit in the same cycle, but the bank is still written.
- R9: With `store_en` low in the cycle that `pkt_end` is sampled, no bank is written and `data_valid_n` does not fall.
- R10: A packet that ends before every byte of its window has arrived is discarded.
- R11: Each commit raises `wr_stb` for exactly one cycle, together with the bank update. `wr_coded` is 1 for a coded-bank write and 0 for a raw-bank write.
- R12: Coded bytes outside positions 13 to 25 are not checked. A double error there does not block the commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| store_en | input | 1 | Allows bank writes when high |
| field_start | input | 1 | Pulse at the start of a data entry window |
| pkt_start | input | 1 | Pulse that opens a line, qualifying `pkt_row` and `pkt_fmt` |
| pkt_row | input | ROW_W (5) | Row designation of the line |
| pkt_fmt | input | FMT_W (4) | Packet format number of the line |
| byte_vld | input | 1 | A sliced byte is present on `byte_in` |
| byte_in | input | 8 | Sliced byte |
| pkt_end | input | 1 | Pulse that closes the line and requests a commit |
| coded_bank | output | CODED_LEN*8 (104) | Stored coded-format bytes |
| raw_bank | output | RAW_LEN*8 (56) | Stored raw-format bytes |
| wr_stb | output | 1 | One-cycle pulse when a bank is written |
| wr_coded | output | 1 | Bank selected by the last write (1 = coded) |
| data_valid_n | output | 1 | Active-low flag: coded data stored in this field |

## Verification
Every commit result (bank contents, `wr_stb`, `wr_coded` and the falling flag) appears at the single clock edge that samples `pkt_end`. The flag release appears one edge after `field_start`. The driver pushes the expected bank image and flag for each commit it expects into a queue before that edge. The monitor pops and compares on the falling clock edge right after a strobe. Two cycles after each packet, the bench also checks that the queue is empty and that the banks and flag match the model, which catches writes that are missing or unwanted.

// File: rtl/hpx_pkg.sv
package hpx_pkg;

    typedef enum logic [1:0] {
        HD_CLEAN  = 2'd0,
        HD_FIXED  = 2'd1,
        HD_DOUBLE = 2'd2
    } ham_stat_e;

    typedef struct packed {
        logic [7:0] data;
        ham_stat_e  stat;
    } ham_res_t;

endpackage

// File: rtl/hpx_ham84_dec.sv
module hpx_ham84_dec
    import hpx_pkg::*;
(
    input  logic [7:0] code_i,
    output ham_res_t   res_o
);

    logic       chk_a;
    logic       chk_b;
    logic       chk_c;
    logic       par_all;
    logic [2:0] syn;
    logic [7:0] flip;

    always_comb begin
        chk_a   = code_i[0] ^ code_i[1] ^ code_i[5] ^ code_i[7];
        chk_b   = code_i[1] ^ code_i[2] ^ code_i[3] ^ code_i[7];
        chk_c   = code_i[1] ^ code_i[3] ^ code_i[4] ^ code_i[5];
        par_all = ^code_i;
        syn     = {chk_a, chk_b, chk_c};
        flip    = 8'h00;
        case (syn)
            3'b100:  flip[0] = 1'b1;
            3'b111:  flip[1] = 1'b1;
            3'b010:  flip[2] = 1'b1;
            3'b011:  flip[3] = 1'b1;
            3'b001:  flip[4] = 1'b1;
            3'b101:  flip[5] = 1'b1;
            3'b110:  flip[7] = 1'b1;
            default: flip[6] = 1'b1;
        endcase
        if (par_all) begin
            res_o.data = code_i ^ flip;
            res_o.stat = HD_FIXED;
        end else if (syn != 3'b000) begin
            res_o.data = code_i;
            res_o.stat = HD_DOUBLE;
        end else begin
            res_o.data = code_i;
            res_o.stat = HD_CLEAN;
        end
    end

endmodule

// File: rtl/hpx_line_stage.sv
module hpx_line_stage
    import hpx_pkg::*;
#(
    parameter int LINE_BYTES = 45,
    parameter int ROW_W      = 5,
    parameter int FMT_W      = 4,
    parameter int SVC_ROW    = 30,
    parameter int FMT_RAW    = 1,
    parameter int FMT_CODED  = 2,
    parameter int CODED_LO   = 13,
    parameter int CODED_HI   = 25,
    parameter int RAW_LO     = 15,
    parameter int RAW_HI     = 21,
    localparam int CODED_LEN = CODED_HI - CODED_LO + 1,
    localparam int RAW_LEN   = RAW_HI - RAW_LO + 1,
    localparam int BUF_LEN   = (CODED_LEN > RAW_LEN) ? CODED_LEN : RAW_LEN
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pkt_start,
    input  logic [ROW_W-1:0]     pkt_row,
    input  logic [FMT_W-1:0]     pkt_fmt,
    input  logic                 byte_vld,
    input  logic [7:0]           byte_in,
    input  logic                 pkt_end,
    output logic                 done_ok,
    output logic                 done_coded,
    output logic [BUF_LEN*8-1:0] buf_flat
);

    localparam int POS_W = $clog2(LINE_BYTES + 1);
    localparam int CNT_W = $clog2(BUF_LEN + 1);

    localparam logic [POS_W-1:0] P_C_LO = POS_W'(CODED_LO);
    localparam logic [POS_W-1:0] P_C_HI = POS_W'(CODED_HI);
    localparam logic [POS_W-1:0] P_R_LO = POS_W'(RAW_LO);
    localparam logic [POS_W-1:0] P_R_HI = POS_W'(RAW_HI);
    localparam logic [POS_W-1:0] P_MAX  = POS_W'(LINE_BYTES);
    localparam logic [CNT_W-1:0] N_CODED = CNT_W'(CODED_LEN);
    localparam logic [CNT_W-1:0] N_RAW   = CNT_W'(RAW_LEN);

    typedef struct packed {
        logic                     active;
        logic                     coded;
        logic                     bad;
        logic [POS_W-1:0]         pos;
        logic [CNT_W-1:0]         cnt;
        logic [BUF_LEN-1:0][7:0]  bytes;
    } stage_t;

    stage_t           st_d;
    stage_t           st_q;
    ham_res_t         dec_res;
    logic             in_win;
    logic [POS_W-1:0] slot;
    logic [7:0]       wbyte;
    logic [CNT_W-1:0] want;
    logic             row_ok;
    logic             fmt_raw;
    logic             fmt_coded;

    hpx_ham84_dec u_dec (
        .code_i (byte_in),
        .res_o  (dec_res)
    );

    always_comb begin
        st_d      = st_q;
        row_ok    = (pkt_row == ROW_W'(SVC_ROW));
        fmt_raw   = (pkt_fmt == FMT_W'(FMT_RAW));
        fmt_coded = (pkt_fmt == FMT_W'(FMT_CODED));
        if (st_q.coded) begin
            in_win = (st_q.pos >= P_C_LO) && (st_q.pos <= P_C_HI);
            slot   = st_q.pos - P_C_LO;
            wbyte  = dec_res.data;
            want   = N_CODED;
        end else begin
            in_win = (st_q.pos >= P_R_LO) && (st_q.pos <= P_R_HI);
            slot   = st_q.pos - P_R_LO;
            wbyte  = byte_in;
            want   = N_RAW;
        end

        done_ok    = pkt_end && !pkt_start && st_q.active && !st_q.bad
                     && (st_q.cnt == want);
        done_coded = st_q.coded;

        if (pkt_start) begin
            st_d.active = row_ok && (fmt_raw || fmt_coded);
            st_d.coded  = fmt_coded;
            st_d.bad    = 1'b0;
            st_d.pos    = '0;
            st_d.cnt    = '0;
        end else if (pkt_end) begin
            st_d.active = 1'b0;
        end else if (byte_vld && st_q.active) begin
            if (in_win) begin
                for (int k = 0; k < BUF_LEN; k++) begin
                    if (slot == POS_W'(k)) begin
                        st_d.bytes[k] = wbyte;
                    end
                end
                st_d.cnt = st_q.cnt + CNT_W'(1);
                if (st_q.coded && (dec_res.stat == HD_DOUBLE)) begin
                    st_d.bad = 1'b1;
                end
            end
            if (st_q.pos != P_MAX) begin
                st_d.pos = st_q.pos + POS_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign buf_flat = st_q.bytes;

endmodule

// File: rtl/hpx_acq_bank.sv
module hpx_acq_bank #(
    parameter int CODED_LEN = 13,
    parameter int RAW_LEN   = 7,
    parameter int BUF_LEN   = 13
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   commit_ok,
    input  logic                   commit_coded,
    input  logic                   store_en,
    input  logic                   field_start,
    input  logic [BUF_LEN*8-1:0]   buf_flat,
    output logic [CODED_LEN*8-1:0] coded_bank,
    output logic [RAW_LEN*8-1:0]   raw_bank,
    output logic                   wr_stb,
    output logic                   wr_coded,
    output logic                   data_valid_n
);

    typedef struct packed {
        logic [CODED_LEN-1:0][7:0] cbank;
        logic [RAW_LEN-1:0][7:0]   rbank;
        logic                      stb;
        logic                      sel;
        logic                      dvn;
    } bank_t;

    bank_t      bk_d;
    bank_t      bk_q;
    logic [7:0] buf_b [BUF_LEN];
    logic       do_wr;

    for (genvar g = 0; g < BUF_LEN; g++) begin : g_unpack
        assign buf_b[g] = buf_flat[8*g +: 8];
    end

    always_comb begin
        bk_d     = bk_q;
        bk_d.stb = 1'b0;
        do_wr    = commit_ok && store_en;
        if (do_wr) begin
            bk_d.stb = 1'b1;
            bk_d.sel = commit_coded;
            if (commit_coded) begin
                for (int k = 0; k < CODED_LEN; k++) begin
                    bk_d.cbank[k] = buf_b[k];
                end
            end else begin
                for (int k = 0; k < RAW_LEN; k++) begin
                    bk_d.rbank[k] = buf_b[k];
                end
            end
        end
        if (field_start) begin
            bk_d.dvn = 1'b1;
        end else if (do_wr && commit_coded) begin
            bk_d.dvn = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bk_q.cbank <= '1;
            bk_q.rbank <= '1;
            bk_q.stb   <= 1'b0;
            bk_q.sel   <= 1'b0;
            bk_q.dvn   <= 1'b1;
        end else begin
            bk_q <= bk_d;
        end
    end

    assign coded_bank   = bk_q.cbank;
    assign raw_bank     = bk_q.rbank;
    assign wr_stb       = bk_q.stb;
    assign wr_coded     = bk_q.sel;
    assign data_valid_n = bk_q.dvn;

endmodule

// File: rtl/hamm_pkt_extract.sv
module hamm_pkt_extract #(
    parameter int LINE_BYTES = 45,
    parameter int ROW_W      = 5,
    parameter int FMT_W      = 4,
    parameter int SVC_ROW    = 30,
    parameter int FMT_RAW    = 1,
    parameter int FMT_CODED  = 2,
    parameter int CODED_LO   = 13,
    parameter int CODED_HI   = 25,
    parameter int RAW_LO     = 15,
    parameter int RAW_HI     = 21,
    localparam int CODED_LEN = CODED_HI - CODED_LO + 1,
    localparam int RAW_LEN   = RAW_HI - RAW_LO + 1,
    localparam int BUF_LEN   = (CODED_LEN > RAW_LEN) ? CODED_LEN : RAW_LEN
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   store_en,
    input  logic                   field_start,
    input  logic                   pkt_start,
    input  logic [ROW_W-1:0]       pkt_row,
    input  logic [FMT_W-1:0]       pkt_fmt,
    input  logic                   byte_vld,
    input  logic [7:0]             byte_in,
    input  logic                   pkt_end,
    output logic [CODED_LEN*8-1:0] coded_bank,
    output logic [RAW_LEN*8-1:0]   raw_bank,
    output logic                   wr_stb,
    output logic                   wr_coded,
    output logic                   data_valid_n
);

    logic                 commit_ok;
    logic                 commit_coded;
    logic [BUF_LEN*8-1:0] stage_buf;

    hpx_line_stage #(
        .LINE_BYTES (LINE_BYTES),
        .ROW_W      (ROW_W),
        .FMT_W      (FMT_W),
        .SVC_ROW    (SVC_ROW),
        .FMT_RAW    (FMT_RAW),
        .FMT_CODED  (FMT_CODED),
        .CODED_LO   (CODED_LO),
        .CODED_HI   (CODED_HI),
        .RAW_LO     (RAW_LO),
        .RAW_HI     (RAW_HI)
    ) u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .pkt_start  (pkt_start),
        .pkt_row    (pkt_row),
        .pkt_fmt    (pkt_fmt),
        .byte_vld   (byte_vld),
        .byte_in    (byte_in),
        .pkt_end    (pkt_end),
        .done_ok    (commit_ok),
        .done_coded (commit_coded),
        .buf_flat   (stage_buf)
    );

    hpx_acq_bank #(
        .CODED_LEN (CODED_LEN),
        .RAW_LEN   (RAW_LEN),
        .BUF_LEN   (BUF_LEN)
    ) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .commit_ok    (commit_ok),
        .commit_coded (commit_coded),
        .store_en     (store_en),
        .field_start  (field_start),
        .buf_flat     (stage_buf),
        .coded_bank   (coded_bank),
        .raw_bank     (raw_bank),
        .wr_stb       (wr_stb),
        .wr_coded     (wr_coded),
        .data_valid_n (data_valid_n)
    );

endmodule

// File: rtl/hpx_chk.sv
module hpx_chk #(
    parameter int CODED_LEN = 13,
    parameter int RAW_LEN   = 7
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   store_en,
    input logic                   field_start,
    input logic                   pkt_end,
    input logic [CODED_LEN*8-1:0] coded_bank,
    input logic [RAW_LEN*8-1:0]   raw_bank,
    input logic                   wr_stb,
    input logic                   wr_coded,
    input logic                   data_valid_n
);

    // R1: outputs sit at their reset values while reset is held
    always @(negedge clk) begin
        if (!rst_n) begin
            a_r1_reset_state: assert (data_valid_n && !wr_stb && (&coded_bank) && (&raw_bank));
        end
    end

    // R2: banks only move together with a write strobe
    a_r2_banks_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |-> ($stable(coded_bank) && $stable(raw_bank)));

    // R9: a write needs store enable and end of packet on the previous edge
    a_r9_write_gated: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> ($past(store_en) && $past(pkt_end)));

    // R7: the flag only falls together with a coded-bank write
    a_r7_dv_fall_coded: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_valid_n) |-> (wr_stb && wr_coded));

    // R7: a raw write leaves the flag alone unless a window start intervened
    a_r7_raw_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !wr_coded) |-> ((data_valid_n == $past(data_valid_n)) || $past(field_start)));

    // R8: the flag only rises after a window start
    a_r8_dv_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_valid_n) |-> $past(field_start));

    // R11: the strobe lasts a single cycle
    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

endmodule

bind hamm_pkt_extract hpx_chk #(
    .CODED_LEN (CODED_LEN),
    .RAW_LEN   (RAW_LEN)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .store_en     (store_en),
    .field_start  (field_start),
    .pkt_end      (pkt_end),
    .coded_bank   (coded_bank),
    .raw_bank     (raw_bank),
    .wr_stb       (wr_stb),
    .wr_coded     (wr_coded),
    .data_valid_n (data_valid_n)
);

// File: tb/sim_hamm_pkt_extract.sv
module sim_hamm_pkt_extract;

    localparam int LINE_BYTES = 45;
    localparam int CODED_LO   = 13;
    localparam int RAW_LO     = 15;
    localparam int CODED_LEN  = 13;
    localparam int RAW_LEN    = 7;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   store_en = 1'b1;
    logic                   field_start = 1'b0;
    logic                   pkt_start = 1'b0;
    logic [4:0]             pkt_row = '0;
    logic [3:0]             pkt_fmt = '0;
    logic                   byte_vld = 1'b0;
    logic [7:0]             byte_in = '0;
    logic                   pkt_end = 1'b0;
    logic [CODED_LEN*8-1:0] coded_bank;
    logic [RAW_LEN*8-1:0]   raw_bank;
    logic                   wr_stb;
    logic                   wr_coded;
    logic                   data_valid_n;

    always #2 clk = ~clk;

    hamm_pkt_extract u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .store_en     (store_en),
        .field_start  (field_start),
        .pkt_start    (pkt_start),
        .pkt_row      (pkt_row),
        .pkt_fmt      (pkt_fmt),
        .byte_vld     (byte_vld),
        .byte_in      (byte_in),
        .pkt_end      (pkt_end),
        .coded_bank   (coded_bank),
        .raw_bank     (raw_bank),
        .wr_stb       (wr_stb),
        .wr_coded     (wr_coded),
        .data_valid_n (data_valid_n)
    );

    typedef struct {
        logic                   sel;
        logic                   dvn;
        logic [CODED_LEN*8-1:0] cb;
        logic [RAW_LEN*8-1:0]   rb;
        string                  req;
    } exp_t;

    exp_t       sb_q[$];
    int         n_chk = 0;
    int         n_fail = 0;
    logic [7:0] line_buf [LINE_BYTES];
    logic [7:0] clean    [LINE_BYTES];
    logic [7:0] m_cb     [CODED_LEN];
    logic [7:0] m_rb     [RAW_LEN];
    logic       m_dvn = 1'b1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] enc(input logic [3:0] n);
        logic [7:0] b;
        b    = 8'h00;
        b[1] = n[0];
        b[3] = n[1];
        b[5] = n[2];
        b[7] = n[3];
        b[0] = n[0] ^ n[2] ^ n[3];
        b[2] = n[0] ^ n[1] ^ n[3];
        b[4] = n[0] ^ n[1] ^ n[2];
        b[6] = ^b;
        return b;
    endfunction

    function automatic logic [CODED_LEN*8-1:0] flat_c();
        logic [CODED_LEN*8-1:0] v;
        for (int k = 0; k < CODED_LEN; k++) v[8*k +: 8] = m_cb[k];
        return v;
    endfunction

    function automatic logic [RAW_LEN*8-1:0] flat_r();
        logic [RAW_LEN*8-1:0] v;
        for (int k = 0; k < RAW_LEN; k++) v[8*k +: 8] = m_rb[k];
        return v;
    endfunction

    // line with valid codewords in the coded window and arbitrary bytes elsewhere
    task automatic fill_coded(input int seed);
        for (int i = 0; i < LINE_BYTES; i++) begin
            line_buf[i] = 8'(i * 37 + seed);
            if (i >= CODED_LO && i < CODED_LO + CODED_LEN) line_buf[i] = enc(4'(i + seed));
            clean[i] = line_buf[i];
        end
    endtask

    task automatic fill_raw(input int seed);
        for (int i = 0; i < LINE_BYTES; i++) begin
            line_buf[i] = 8'(i * 53 + seed * 11 + 1);
            clean[i]    = line_buf[i];
        end
    endtask

    // monitor: every strobe must match the oldest expected commit
    always @(negedge clk) begin
        if (rst_n && wr_stb) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R2", "unexpected bank write", 128'(wr_coded), 128'(0));
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(wr_coded == e.sel, e.req, "R11 wr_coded", 128'(wr_coded), 128'(e.sel));
                chk(coded_bank == e.cb, e.req, "coded_bank", 128'(coded_bank), 128'(e.cb));
                chk(raw_bank == e.rb, e.req, "raw_bank", 128'(raw_bank), 128'(e.rb));
                chk(data_valid_n == e.dvn, e.req, "data_valid_n", 128'(data_valid_n), 128'(e.dvn));
            end
        end
    end

    task automatic send(input int row, input int fmt, input int nbytes, input bit st_en,
                        input bit fs_end, input bit expect_wr, input string req);
        @(negedge clk);
        pkt_start = 1'b1;
        pkt_row   = 5'(row);
        pkt_fmt   = 4'(fmt);
        store_en  = st_en;
        for (int i = 0; i < nbytes; i++) begin
            @(negedge clk);
            pkt_start = 1'b0;
            byte_vld  = 1'b1;
            byte_in   = line_buf[i];
        end
        @(negedge clk);
        pkt_start   = 1'b0;
        byte_vld    = 1'b0;
        pkt_end     = 1'b1;
        field_start = fs_end;
        if (expect_wr) begin
            exp_t e;
            if (fmt == 2) begin
                for (int k = 0; k < CODED_LEN; k++) m_cb[k] = clean[CODED_LO + k];
            end else begin
                for (int k = 0; k < RAW_LEN; k++) m_rb[k] = clean[RAW_LO + k];
            end
            if (fs_end) m_dvn = 1'b1;
            else if (fmt == 2) m_dvn = 1'b0;
            e.sel = (fmt == 2);
            e.dvn = m_dvn;
            e.cb  = flat_c();
            e.rb  = flat_r();
            e.req = req;
            sb_q.push_back(e);
        end else if (fs_end) begin
            m_dvn = 1'b1;
        end
        @(negedge clk);
        pkt_end     = 1'b0;
        field_start = 1'b0;
        store_en    = 1'b1;
        repeat (2) @(negedge clk);
        chk(sb_q.size() == 0, req, "expected write missing", 128'(sb_q.size()), 128'(0));
        sb_q.delete();
        chk(coded_bank == flat_c(), req, "coded_bank after packet", 128'(coded_bank), 128'(flat_c()));
        chk(raw_bank == flat_r(), req, "raw_bank after packet", 128'(raw_bank), 128'(flat_r()));
        chk(data_valid_n == m_dvn, req, "data_valid_n after packet", 128'(data_valid_n), 128'(m_dvn));
    endtask

    task automatic window_start();
        @(negedge clk);
        field_start = 1'b1;
        @(negedge clk);
        field_start = 1'b0;
        m_dvn = 1'b1;
        chk(data_valid_n == 1'b1, "R8", "flag after window start", 128'(data_valid_n), 128'(1));
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "all", "watchdog expired", 128'(0), 128'(1));
        summary();
        $finish;
    end

    initial begin
        for (int k = 0; k < CODED_LEN; k++) m_cb[k] = 8'hFF;
        for (int k = 0; k < RAW_LEN; k++) m_rb[k] = 8'hFF;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(data_valid_n == 1'b1, "R1", "flag in reset", 128'(data_valid_n), 128'(1));
        chk(wr_stb == 1'b0, "R1", "strobe in reset", 128'(wr_stb), 128'(0));
        chk(&coded_bank, "R1", "coded bank in reset", 128'(coded_bank), 128'(flat_c()));
        chk(&raw_bank, "R1", "raw bank in reset", 128'(raw_bank), 128'(flat_r()));
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3 R7 R11: clean coded packet stored, flag falls
        fill_coded(1);
        send(30, 2, LINE_BYTES, 1'b1, 1'b0, 1'b1, "R3");
        window_start();

        // R4: one flipped bit in each of the eight bit positions
        fill_coded(6);
        for (int b = 0; b < 8; b++) line_buf[CODED_LO + b] ^= 8'(1 << b);
        send(30, 2, LINE_BYTES, 1'b1, 1'b0, 1'b1, "R4");

        // R6 R7: raw packet while flag low, includes invalid codewords, flag stays low
        fill_raw(2);
        send(30, 1, LINE_BYTES, 1'b1, 1'b0, 1'b1, "R6");
        window_start();

        // R7: raw packet while flag high, flag stays high
        fill_raw(9);
        line_buf[RAW_LO + 2] = 8'h03;
        clean[RAW_LO + 2]    = 8'h03;
        send(30, 1, LINE_BYTES, 1'b1, 1'b0, 1'b1, "R7");

        // R5: double error inside the coded window drops the packet
        fill_coded(4);
        line_buf[20] ^= 8'h03;
        send(30, 2, LINE_BYTES, 1'b1, 1'b0, 1'b0, "R5");

        // R12: double errors outside the coded window do not block the commit
        fill_coded(5);
        line_buf[5]  = enc(4'h9) ^ 8'h03;
        line_buf[30] = enc(4'h2) ^ 8'h30;
        send(30, 2, LINE_BYTES, 1'b1, 1'b0, 1'b1, "R12");
        window_start();

        // R2: wrong row, then unsupported format
        fill_coded(7);
        send(29, 2, LINE_BYTES, 1'b1, 1'b0, 1'b0, "R2");
        send(30, 3, LINE_BYTES, 1'b1, 1'b0, 1'b0, "R2");

        // R9: store enable low blocks the write and the flag
        fill_coded(8);
        send(30, 2, LINE_BYTES, 1'b0, 1'b0, 1'b0, "R9");
        fill_raw(3);
        send(30, 1, LINE_BYTES, 1'b0, 1'b0, 1'b0, "R9");

        // R10: line ends before the coded window is complete
        fill_coded(10);
        send(30, 2, 20, 1'b1, 1'b0, 1'b0, "R10");

        // R8: window start coinciding with a coded commit keeps flag high
        fill_coded(11);
        send(30, 2, LINE_BYTES, 1'b1, 1'b1, 1'b1, "R8");

        summary();
        $finish;
    end

endmodule